// File: doc/BRIEF.md
# Policy-Driven APB Register Bank

This block is an APB3 slave with a 16-bit address and 32-bit data. It holds a fixed bank of thirty 32-bit registers, one per word address. Each register carries one software access policy, which decides what a bus write and a bus read do to the stored value. The policies cover the following kinds of behaviour:

- plain storage;
- clear or set on write;
- per-bit clear, set or toggle on written ones or zeros;
- clear or set as a side effect of a read;
- write-only, where a read reports an error;
- write-once;
- one-cycle pulses;
- storage that hardware can also load;
- a fixed constant;
- a live hardware input.

Reads return data with no wait state. An address outside the bank reads back a programmable constant and never reports an error. Register `k` sits at byte address `4*k`, and address bits [1:0] are ignored. Read side effects take place only in the access phase of a read to the matching register, so each happens once per transfer. Reset is synchronous and active low.

Top module: `apb_policy_regbank`

## Requirements
- R1: On reset every stored register takes its reset value. The reset values are 0xA5A5A5A5 at 0x04 and 0xFFFFFFFF at 0x14, 0x24 and 0x30; all other stored registers reset to 0. The plain read-write register at 0x00 returns the last value written to it. `pready` is 1 at all times.
- R2: Per-bit write policies act on set bits or on clear bits of the write data and leave the other bits unchanged:
  - 0x24 clears bits written as 1;
  - 0x28 sets bits written as 1;
  - 0x2C toggles bits written as 1;
  - 0x30 clears bits written as 0;
  - 0x34 sets bits written as 0;
  - 0x38 toggles bits written as 0.
- R3: Whole-value policies:
  - 0x14 becomes all zeros on any write;
  - 0x18 becomes all ones on any write;
  - 0x04 returns its value on a read, then holds all zeros, and ignores writes;
  - 0x08 returns its value on a read, then holds all ones, and ignores writes.
- R4: Combined policies apply the write effect on a write and the read effect on a read:
  - 0x0C stores as-is and clears on read;
  - 0x10 stores as-is and sets on read;
  - 0x1C sets all on write and clears on read;
  - 0x20 clears all on write and sets on read;
  - 0x3C sets on ones and clears on read;
  - 0x40 clears on ones and sets on read;
  - 0x44 sets on zeros and clears on read;
  - 0x48 clears on zeros and sets on read.
- R5: A read side effect happens only in the access phase of a read to that register. Setup-phase cycles, however many, leave the value unchanged.
- R6: A read of a write-only register returns `pslverr`=1 and `prdata`=0. The write-only registers are 0x4C (stores as-is), 0x50 (clears), 0x54 (sets) and 0x5C (write-once). A read of any other mapped register returns `pslverr`=0.
- R7: The write-once registers at 0x58 and 0x5C accept only the first write after reset. Later writes leave the value unchanged.
- R8: A write to 0x60 drives `pulse_one_o` with the write data, and a write to 0x64 drives `pulse_zero_o` with the inverted write data. Each pulse lasts exactly one cycle, starting in the cycle after the access phase. Both registers read as 0.
- R9: When `hw_set` and a bus write arrive in the same cycle, the hardware value wins at 0x68 and the bus data wins at 0x6C. Without a bus write, `hw_set` loads `hw_set_val` into both registers.
- R10: A read of any address at or above 0x78 completes with `pslverr`=0 and returns `UNMAPPED_VALUE`. A write there changes no register.
- R11: 0x70 always reads as `VERSION`, whatever is written to it. 0x74 reads the live value of `ro_in` and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase marker |
| pwrite | input | 1 | 1 = write transfer |
| paddr | input | 16 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Read error for write-only registers |
| hw_set | input | 1 | Hardware load strobe for 0x68 and 0x6C |
| hw_set_val | input | 32 | Value loaded by `hw_set` |
| ro_in | input | 32 | Live value shown at 0x74 |
| pulse_one_o | output | 32 | One-cycle pulses from writes to 0x60 |
| pulse_zero_o | output | 32 | One-cycle pulses from writes to 0x64 |

## Verification
The hardest situation to reach from the ports is a hardware load and a bus write landing on the same clock edge. This is the only case where the two hardware-set registers behave differently. The bench raises `hw_set` in exactly the access-phase cycle of a write and then reads both registers back. The second hard case is a read side effect that must not fire during setup. The bench holds a read in its setup phase for several cycles before enabling it, and checks that the value read back was not cleared early.

// File: rtl/regbank_pkg.sv
// Shared definitions for the policy register bank.
// Assumes a bank of REG_COUNT word registers.
// Register k uses the policy whose enum value is k.
package regbank_pkg;

    localparam int REG_COUNT = 30;

    typedef enum logic [4:0] {
        ACC_RW, ACC_RC, ACC_RS, ACC_WRC, ACC_WRS, ACC_WC, ACC_WS, ACC_WSRC,
        ACC_WCRS, ACC_W1C, ACC_W1S, ACC_W1T, ACC_W0C, ACC_W0S, ACC_W0T,
        ACC_W1SRC, ACC_W1CRS, ACC_W0SRC, ACC_W0CRS, ACC_WO, ACC_WOC, ACC_WOS,
        ACC_W1, ACC_WO1, ACC_W1P, ACC_W0P, ACC_HSRW, ACC_RWHS, ACC_ROV, ACC_RO
    } acc_e;

    // Reset value of register idx (ROV is supplied by the top).
    function automatic logic [31:0] rst_of(int unsigned idx);
        case (idx)
            1:          return 32'hA5A5_A5A5;
            5, 9, 12:   return 32'hFFFF_FFFF;
            default:    return 32'h0;
        endcase
    endfunction

    // True when a read of this policy must report an error.
    function automatic logic is_write_only(acc_e a);
        return a inside {ACC_WO, ACC_WOC, ACC_WOS, ACC_WO1};
    endfunction

    // True when a read clears the stored value.
    function automatic logic rd_clears(acc_e a);
        return a inside {ACC_RC, ACC_WRC, ACC_WSRC, ACC_W1SRC, ACC_W0SRC};
    endfunction

    // True when a read sets the stored value to all ones.
    function automatic logic rd_sets(acc_e a);
        return a inside {ACC_RS, ACC_WRS, ACC_WCRS, ACC_W1CRS, ACC_W0CRS};
    endfunction

endpackage

// File: rtl/regbank_field.sv
// One register with a fixed access policy.
// Assumes wr_en and rd_en are single-cycle access-phase strobes that never
// assert together. rd_data and rd_err are combinational.
// The pulse output is registered and is nonzero only for the pulse policies.
module regbank_field
    import regbank_pkg::*;
#(
    parameter int          W   = 32,
    parameter acc_e        ACC = ACC_RW,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         rd_en,
    input  logic [W-1:0] wdata,
    input  logic         hw_set,
    input  logic [W-1:0] hw_val,
    input  logic [W-1:0] ro_val,
    output logic [W-1:0] rd_data,
    output logic         rd_err,
    output logic [W-1:0] pulse
);

    localparam logic IS_PULSE = (ACC == ACC_W1P) || (ACC == ACC_W0P);
    localparam logic IS_ONCE  = (ACC == ACC_W1) || (ACC == ACC_WO1);

    logic [W-1:0] q;
    logic [W-1:0] wr_next;
    logic         wr_changes;
    logic         once_done;

    // Purpose: value a bus write would leave, and whether writes act at all.
    always_comb begin
        wr_changes = 1'b1;
        case (ACC)
            ACC_WC, ACC_WOC, ACC_WCRS:   wr_next = '0;
            ACC_WS, ACC_WOS, ACC_WSRC:   wr_next = '1;
            ACC_W1C, ACC_W1CRS:          wr_next = q & ~wdata;
            ACC_W1S, ACC_W1SRC:          wr_next = q | wdata;
            ACC_W1T:                     wr_next = q ^ wdata;
            ACC_W0C, ACC_W0CRS:          wr_next = q & wdata;
            ACC_W0S, ACC_W0SRC:          wr_next = q | ~wdata;
            ACC_W0T:                     wr_next = q ^ ~wdata;
            ACC_RC, ACC_RS, ACC_ROV, ACC_RO: begin
                wr_next    = q;
                wr_changes = 1'b0;
            end
            default:                     wr_next = wdata;
        endcase
    end

    // Purpose: storage update by write, read side effect or hardware load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q         <= RST;
            once_done <= 1'b0;
        end else if (ACC == ACC_HSRW) begin
            if (hw_set)     q <= hw_val;
            else if (wr_en) q <= wdata;
        end else if (ACC == ACC_RWHS) begin
            if (wr_en)       q <= wdata;
            else if (hw_set) q <= hw_val;
        end else if (IS_PULSE) begin
            q <= wr_en ? ((ACC == ACC_W1P) ? wdata : ~wdata) : '0;
        end else if (IS_ONCE) begin
            if (wr_en && !once_done) begin
                q         <= wdata;
                once_done <= 1'b1;
            end
        end else if (wr_en && wr_changes) begin
            q <= wr_next;
        end else if (rd_en && rd_clears(ACC)) begin
            q <= '0;
        end else if (rd_en && rd_sets(ACC)) begin
            q <= '1;
        end
    end

    // Purpose: read-back value per policy.
    always_comb begin
        if (ACC == ACC_ROV)                         rd_data = RST;
        else if (ACC == ACC_RO)                     rd_data = ro_val;
        else if (is_write_only(ACC) || IS_PULSE)    rd_data = '0;
        else                                        rd_data = q;
    end

    assign rd_err = is_write_only(ACC);
    assign pulse  = IS_PULSE ? q : '0;

    if (rd_clears(ACC)) begin : g_chk_rc
        assert_clear_on_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
            rd_en |=> (q == '0));
    end
    if (ACC == ACC_W1C) begin : g_chk_w1c
        assert_w1c_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |=> (q == ($past(q) & ~$past(wdata))));
    end
    if (IS_ONCE) begin : g_chk_once
        assert_write_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (once_done && wr_en) |=> $stable(q));
    end
    if (ACC == ACC_HSRW) begin : g_chk_hsrw
        assert_hw_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
            hw_set |=> (q == $past(hw_val)));
    end
    if (ACC == ACC_RWHS) begin : g_chk_rwhs
        assert_sw_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |=> (q == $past(wdata)));
    end
    if (ACC == ACC_W1P) begin : g_chk_pulse
        assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en |=> (pulse == '0));
    end

endmodule

// File: rtl/apb_policy_regbank.sv
// APB3 slave holding REG_COUNT word registers, register k at byte address 4*k.
// Each register gets the access policy with enum value k.
// Assumes no wait states: pready is tied high.
// Unmapped reads return UNMAPPED_VALUE with no error; unmapped writes are dropped.
module apb_policy_regbank
    import regbank_pkg::*;
#(
    parameter int                ADDR_W         = 16,
    parameter int                DATA_W         = 32,
    parameter logic [DATA_W-1:0] UNMAPPED_VALUE = '0,
    parameter logic [DATA_W-1:0] VERSION        = 32'hF000_A801
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              hw_set,
    input  logic [DATA_W-1:0] hw_set_val,
    input  logic [DATA_W-1:0] ro_in,
    output logic [DATA_W-1:0] pulse_one_o,
    output logic [DATA_W-1:0] pulse_zero_o
);

    localparam int IDX_W = ADDR_W - 2;
    localparam int SEL_W = $clog2(REG_COUNT);

    logic [IDX_W-1:0]  idx;
    logic [SEL_W-1:0]  sel;
    logic              mapped;
    logic              access;
    logic [DATA_W-1:0] rd_val [REG_COUNT];
    logic              rd_err [REG_COUNT];
    logic [DATA_W-1:0] pls    [REG_COUNT];

    assign idx    = paddr[ADDR_W-1:2];
    assign sel    = idx[SEL_W-1:0];
    assign mapped = (idx < IDX_W'(REG_COUNT));
    assign access = psel && penable;
    assign pready = 1'b1;

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
        localparam acc_e              A  = acc_e'(g);
        localparam logic [DATA_W-1:0] RV = (A == ACC_ROV) ? VERSION : DATA_W'(rst_of(g));
        regbank_field #(.W(DATA_W), .ACC(A), .RST(RV)) u_fld (
            .clk     (pclk),
            .rst_n   (presetn),
            .wr_en   (access && pwrite && mapped && (sel == SEL_W'(g))),
            .rd_en   (access && !pwrite && mapped && (sel == SEL_W'(g))),
            .wdata   (pwdata),
            .hw_set  (hw_set),
            .hw_val  (hw_set_val),
            .ro_val  (ro_in),
            .rd_data (rd_val[g]),
            .rd_err  (rd_err[g]),
            .pulse   (pls[g])
        );
    end

    // Purpose: read data and error mux.
    always_comb begin
        if (mapped) begin
            prdata  = rd_val[sel];
            pslverr = access && !pwrite && rd_err[sel];
        end else begin
            prdata  = UNMAPPED_VALUE;
            pslverr = 1'b0;
        end
    end

    // Purpose: route the pulse registers to their outputs.
    always_comb begin
        pulse_one_o  = '0;
        pulse_zero_o = '0;
        for (int k = 0; k < REG_COUNT; k++) begin
            if (acc_e'(k) == ACC_W1P) pulse_one_o  = pulse_one_o  | pls[k];
            if (acc_e'(k) == ACC_W0P) pulse_zero_o = pulse_zero_o | pls[k];
        end
    end

    assert_unmapped_read_R10: assert property (@(posedge pclk) disable iff (!presetn)
        (access && !pwrite && !mapped) |-> (!pslverr && prdata == UNMAPPED_VALUE));

    assert_wo_read_err_R6: assert property (@(posedge pclk) disable iff (!presetn)
        (access && !pwrite && mapped && sel == SEL_W'(ACC_WO)) |-> (pslverr && prdata == '0));

endmodule

// File: tb/sim_apb_policy_regbank.sv
module sim_apb_policy_regbank;

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [15:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic        hw_set = 1'b0;
    logic [31:0] hw_set_val = '0, ro_in = '0;
    logic [31:0] pulse_one_o, pulse_zero_o;

    int checks = 0;
    int errors = 0;

    always #2 pclk = ~pclk;

    apb_policy_regbank #(.UNMAPPED_VALUE(32'h0000_EF00)) u0 (
        .pclk, .presetn, .psel, .penable, .pwrite, .paddr, .pwdata,
        .prdata, .pready, .pslverr, .hw_set, .hw_set_val, .ro_in,
        .pulse_one_o, .pulse_zero_o
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge pclk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge pclk); penable = 1;
        @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d, output logic e);
        @(negedge pclk); psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge pclk); penable = 1; #1; d = prdata; e = pslverr;
        @(negedge pclk); psel = 0; penable = 0;
    endtask

    task automatic rd_chk(input string req, input logic [15:0] a,
                          input logic [31:0] exp, input logic exp_err);
        logic [31:0] d; logic e;
        rd(a, d, e);
        chk(req, d, exp);
        chk({req, " err"}, {31'b0, e}, {31'b0, exp_err});
    endtask

    task automatic t_reset;
        chk("R1 pready", {31'b0, pready}, 32'h1);
        rd_chk("R1 rw reset", 16'h00, 32'h0, 0);
        rd_chk("R1 w1c reset", 16'h24, 32'hFFFF_FFFF, 0);
    endtask

    task automatic t_rw;
        wr(16'h00, 32'hDEAD_BEEF);
        rd_chk("R1 rw readback", 16'h00, 32'hDEAD_BEEF, 0);
        rd_chk("R1 rw offset bits ignored", 16'h03, 32'hDEAD_BEEF, 0);
    endtask

    task automatic t_bitwise;
        wr(16'h24, 32'h0000_F00F); rd_chk("R2 w1c", 16'h24, 32'hFFFF_0FF0, 0);
        wr(16'h28, 32'h11);  wr(16'h28, 32'h101); rd_chk("R2 w1s", 16'h28, 32'h111, 0);
        wr(16'h2C, 32'hF0);  wr(16'h2C, 32'h3C);  rd_chk("R2 w1t", 16'h2C, 32'hCC, 0);
        wr(16'h30, 32'hFFFF_FF00); rd_chk("R2 w0c", 16'h30, 32'hFFFF_FF00, 0);
        wr(16'h34, 32'hFFFF_FFFE); rd_chk("R2 w0s", 16'h34, 32'h1, 0);
        wr(16'h38, 32'hFFFF_0000); rd_chk("R2 w0t", 16'h38, 32'h0000_FFFF, 0);
    endtask

    task automatic t_whole;
        wr(16'h04, 32'h1234_5678);
        rd_chk("R3 rc first", 16'h04, 32'hA5A5_A5A5, 0);
        rd_chk("R3 rc cleared", 16'h04, 32'h0, 0);
        rd_chk("R3 rs first", 16'h08, 32'h0, 0);
        wr(16'h08, 32'h0);
        rd_chk("R3 rs set", 16'h08, 32'hFFFF_FFFF, 0);
        wr(16'h14, 32'h1234); rd_chk("R3 wc", 16'h14, 32'h0, 0);
        wr(16'h18, 32'h0);    rd_chk("R3 ws", 16'h18, 32'hFFFF_FFFF, 0);
    endtask

    task automatic t_combined;
        wr(16'h0C, 32'hCAFE_0001);
        rd_chk("R4 wrc value", 16'h0C, 32'hCAFE_0001, 0);
        rd_chk("R4 wrc cleared", 16'h0C, 32'h0, 0);
        wr(16'h3C, 32'hF0);
        rd_chk("R4 w1src value", 16'h3C, 32'hF0, 0);
        rd_chk("R4 w1src cleared", 16'h3C, 32'h0, 0);
        wr(16'h20, 32'h55);
        rd_chk("R4 wcrs value", 16'h20, 32'h0, 0);
        rd_chk("R4 wcrs set", 16'h20, 32'hFFFF_FFFF, 0);
    endtask

    task automatic t_setup_hold;
        logic [31:0] d;
        wr(16'h0C, 32'h0BAD_F00D);
        @(negedge pclk); psel = 1; penable = 0; pwrite = 0; paddr = 16'h0C;
        repeat (3) @(negedge pclk);
        penable = 1; #1; d = prdata;
        @(negedge pclk); psel = 0; penable = 0;
        chk("R5 setup phase no side effect", d, 32'h0BAD_F00D);
        rd_chk("R5 cleared once after access", 16'h0C, 32'h0, 0);
    endtask

    task automatic t_write_only;
        wr(16'h4C, 32'h55);
        rd_chk("R6 wo read", 16'h4C, 32'h0, 1);
        rd_chk("R6 wos read", 16'h54, 32'h0, 1);
    endtask

    task automatic t_once;
        wr(16'h58, 32'h11); wr(16'h58, 32'h22);
        rd_chk("R7 write once keeps first", 16'h58, 32'h11, 0);
        wr(16'h5C, 32'h33);
        rd_chk("R7 wo1 read", 16'h5C, 32'h0, 1);
    endtask

    task automatic t_pulse;
        wr(16'h60, 32'h5);
        chk("R8 pulse one high", pulse_one_o, 32'h5);
        @(negedge pclk);
        chk("R8 pulse one single cycle", pulse_one_o, 32'h0);
        wr(16'h64, 32'hFFFF_FFF0);
        chk("R8 pulse zero high", pulse_zero_o, 32'hF);
        @(negedge pclk);
        chk("R8 pulse zero single cycle", pulse_zero_o, 32'h0);
        rd_chk("R8 pulse reads zero", 16'h60, 32'h0, 0);
    endtask

    task automatic collide(input logic [15:0] a, input logic [31:0] d, input logic [31:0] h);
        @(negedge pclk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge pclk); penable = 1; hw_set = 1; hw_set_val = h;
        @(negedge pclk); psel = 0; penable = 0; pwrite = 0; hw_set = 0;
    endtask

    task automatic t_hwset;
        collide(16'h68, 32'h5555, 32'hAAAA);
        rd_chk("R9 hw wins", 16'h68, 32'hAAAA, 0);
        collide(16'h6C, 32'h1357, 32'h2468);
        rd_chk("R9 sw wins", 16'h6C, 32'h1357, 0);
        @(negedge pclk); hw_set = 1; hw_set_val = 32'h77;
        @(negedge pclk); hw_set = 0;
        rd_chk("R9 hw alone", 16'h6C, 32'h77, 0);
    endtask

    task automatic t_unmapped;
        rd_chk("R10 first unmapped", 16'h78, 32'h0000_EF00, 0);
        rd_chk("R10 top address", 16'hFFFC, 32'h0000_EF00, 0);
        wr(16'h78, 32'h0);
        rd_chk("R10 write ignored", 16'h00, 32'hDEAD_BEEF, 0);
    endtask

    task automatic t_const;
        rd_chk("R11 version", 16'h70, 32'hF000_A801, 0);
        wr(16'h70, 32'h0);
        rd_chk("R11 version after write", 16'h70, 32'hF000_A801, 0);
        ro_in = 32'h1357_2468;
        rd_chk("R11 live input", 16'h74, 32'h1357_2468, 0);
        ro_in = 32'h0000_00AB;
        rd_chk("R11 live input change", 16'h74, 32'hAB, 0);
    endtask

    initial begin
        repeat (3) @(negedge pclk);
        presetn = 1;
        t_reset(); t_rw(); t_bitwise(); t_whole(); t_combined();
        t_setup_hold(); t_write_only(); t_once(); t_pulse();
        t_hwset(); t_unmapped(); t_const();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge pclk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule